// File: doc/BRIEF.md
# Vector Operand Index Relocation Unit

This block sits in the operand-decode stage of a vector processor. It takes the register specifiers of each issued vector instruction: three sources and one destination. It can shift chosen vector operands by a programmable index, so that software can walk through the vector register file without rewriting instructions. There are two configuration registers, both loaded through one write port. A mode control register holds a global indexing enable. An index register holds the 8-bit offset and a four-bit mask that picks which operands are relocated.

Each operand specifier is 9 bits wide. Values 256 to 511 name vector registers 0 to 255. Lower values name scalar registers, constants or other special operands. When an operand is picked for relocation, the block adds the offset to its vector register number. If the result falls past the last allocated vector register, the operand becomes vector register 0 (specifier 256). An operand that was not a vector register in the first place also becomes vector register 0. The final specifiers come out one cycle after the instruction is presented, with a valid strobe and a per-operand flag that marks each forced substitution.

Top module: `vreg_reloc_unit`

## Requirements
- R1: During and after a synchronous reset, `out_valid`, every output specifier and every `out_forced` bit read 0, and both configuration registers are cleared, so indexing starts disabled.
- R2: `out_valid` equals `in_valid` delayed by one clock. The output specifiers and flags load only when `in_valid` is high and hold their values otherwise.
- R3: While bit 27 of the mode control register (`cfg_sel`=0) is 0, every operand passes through unchanged with its flag clear, whatever the index register holds.
- R4: For a relocated vector operand, the output is 256 + (input − 256) + index. The index is bits 7:0 of the index register (`cfg_sel`=1).
- R5: Bits 12, 13, 14 and 15 of the index register select relocation for source 0, source 1, source 2 and the destination, in that order. An operand whose bit is 0 passes through unchanged.
- R6: If a relocated register number is greater than or equal to `vreg_count`, the output is 256 and the operand's flag is set. A number equal to `vreg_count` − 1 is kept.
- R7: The range check uses the full 9-bit sum, so an addition that passes 255 is caught as out of range even when `vreg_count` is 256.
- R8: A relocated operand with a specifier below 256 (not a vector register) is output as 256 and its flag is set.
- R9: A configuration write changes the result only for instructions presented on later cycles. An instruction presented in the same cycle as the write still sees the old values.
- R10: `out_forced[k]` is set exactly when operand k (0..2 the sources, 3 the destination) was replaced by vector register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target register: 0 = mode control, 1 = index |
| cfg_wdata | input | 32 | Configuration write data |
| vreg_count | input | 9 | Number of allocated vector registers (1 to 256) |
| in_valid | input | 1 | Instruction operands valid |
| in_src0 | input | 9 | Source operand 0 specifier |
| in_src1 | input | 9 | Source operand 1 specifier |
| in_src2 | input | 9 | Source operand 2 specifier |
| in_dst | input | 9 | Destination operand specifier |
| out_valid | output | 1 | Output operands valid |
| out_src0 | output | 9 | Final source operand 0 specifier |
| out_src1 | output | 9 | Final source operand 1 specifier |
| out_src2 | output | 9 | Final source operand 2 specifier |
| out_dst | output | 9 | Final destination specifier |
| out_forced | output | 4 | Per-operand substitution flags (bit 3 = destination) |

## Verification
The bench drives the range boundary from both sides: it places a sum at `vreg_count` − 1 and one at `vreg_count`. A design with an off-by-one compare would either drop the last register or let one register too many through. It also adds an index that carries past 255 with all 256 registers allocated. An 8-bit adder would wrap this to a low register number and not force register 0. The bench writes configuration in the same cycle as an instruction, which exposes a write that bypasses into the current result. It sets mask bits one at a time to catch swapped operand lanes, and it sends scalar operands through with the mask set, which a design that skipped the non-vector check would pass unchanged.

// File: rtl/vri_pkg.sv
package vri_pkg;

    localparam int SPEC_W      = 9;
    localparam int VNUM_W      = SPEC_W - 1;
    localparam int IDX_W       = 8;
    localparam int NUM_OPS     = 4;
    localparam int CFG_W       = 32;
    localparam int MODE_EN_BIT = 27;
    localparam int IDX_LSB     = 0;
    localparam int MASK_LSB    = 12;
    localparam int SUM_W       = (VNUM_W > IDX_W ? VNUM_W : IDX_W) + 1;

    typedef logic [SPEC_W-1:0] spec_t;

    typedef enum logic {
        CFG_MODE  = 1'b0,
        CFG_INDEX = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic               en;
        logic [IDX_W-1:0]   idx;
        logic [NUM_OPS-1:0] mask;
    } reloc_cfg_t;

    typedef struct packed {
        logic  forced;
        spec_t spec;
    } op_res_t;

    // Vector registers occupy the upper half of the specifier space.
    function automatic logic is_vreg(spec_t s);
        return s[SPEC_W-1];
    endfunction

    function automatic spec_t vreg_spec(logic [VNUM_W-1:0] n);
        return {1'b1, n};
    endfunction

endpackage

// File: rtl/vri_cfg_regs.sv
module vri_cfg_regs
    import vri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output reloc_cfg_t       cfg
);

    logic               en_q;
    logic [IDX_W-1:0]   idx_q;
    logic [NUM_OPS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            idx_q  <= '0;
            mask_q <= '0;
        end else if (we) begin
            if (cfg_sel_e'(sel) == CFG_MODE) begin
                en_q <= wdata[MODE_EN_BIT];
            end else begin
                idx_q  <= wdata[IDX_LSB +: IDX_W];
                mask_q <= wdata[MASK_LSB +: NUM_OPS];
            end
        end
    end

    always_comb begin
        cfg.en   = en_q;
        cfg.idx  = idx_q;
        cfg.mask = mask_q;
    end

endmodule

// File: rtl/vri_operand_map.sv
module vri_operand_map
    import vri_pkg::*;
(
    input  spec_t            spec_in,
    input  logic             apply,
    input  logic [IDX_W-1:0] idx,
    input  logic [SPEC_W-1:0] vreg_count,
    output op_res_t          res
);

    logic [SUM_W-1:0] sum;
    logic             out_of_range;

    always_comb begin
        sum          = SUM_W'(spec_in[VNUM_W-1:0]) + SUM_W'(idx);
        out_of_range = sum >= SUM_W'(vreg_count);
    end

    always_comb begin
        res.forced = 1'b0;
        res.spec   = spec_in;
        if (apply) begin
            if (!is_vreg(spec_in) || out_of_range) begin
                res.forced = 1'b1;
                res.spec   = vreg_spec('0);
            end else begin
                res.spec   = vreg_spec(sum[VNUM_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/vri_out_stage.sv
module vri_out_stage
    import vri_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  op_res_t            res [NUM_OPS],
    output logic               out_valid,
    output spec_t              out_spec [NUM_OPS],
    output logic [NUM_OPS-1:0] out_forced
);

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                out_spec[k]   <= '0;
                out_forced[k] <= 1'b0;
            end else if (in_valid) begin
                out_spec[k]   <= res[k].spec;
                out_forced[k] <= res[k].forced;
            end
        end
    end

endmodule

// File: rtl/vreg_reloc_unit.sv
module vreg_reloc_unit
    import vri_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [8:0]  vreg_count,
    input  logic        in_valid,
    input  logic [8:0]  in_src0,
    input  logic [8:0]  in_src1,
    input  logic [8:0]  in_src2,
    input  logic [8:0]  in_dst,
    output logic        out_valid,
    output logic [8:0]  out_src0,
    output logic [8:0]  out_src1,
    output logic [8:0]  out_src2,
    output logic [8:0]  out_dst,
    output logic [3:0]  out_forced
);

    reloc_cfg_t         cfg;
    spec_t              in_spec  [NUM_OPS];
    op_res_t            res      [NUM_OPS];
    spec_t              out_spec [NUM_OPS];
    logic               idx_en;
    logic [NUM_OPS-1:0] idx_mask;

    vri_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign idx_en   = cfg.en;
    assign idx_mask = cfg.mask;

    assign in_spec[0] = in_src0;
    assign in_spec[1] = in_src1;
    assign in_spec[2] = in_src2;
    assign in_spec[3] = in_dst;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        vri_operand_map u_map (
            .spec_in    (in_spec[k]),
            .apply      (idx_en & idx_mask[k]),
            .idx        (cfg.idx),
            .vreg_count (vreg_count),
            .res        (res[k])
        );
    end

    vri_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .res        (res),
        .out_valid  (out_valid),
        .out_spec   (out_spec),
        .out_forced (out_forced)
    );

    assign out_src0 = out_spec[0];
    assign out_src1 = out_spec[1];
    assign out_src2 = out_spec[2];
    assign out_dst  = out_spec[3];

endmodule

// File: rtl/vri_checker.sv
module vri_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_valid,
    input logic [8:0] out_src0,
    input logic [8:0] out_src1,
    input logic [8:0] out_src2,
    input logic [8:0] out_dst,
    input logic [3:0] out_forced,
    input logic       idx_en,
    input logic [3:0] idx_mask
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_forced_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !idx_en) |=> (out_forced == 4'b0));

    assert_forced_needs_mask_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_forced & ~$past(idx_mask)) == 4'b0));

    assert_forced_is_zero_src0_R10: assert property (@(posedge clk) disable iff (rst)
        out_forced[0] |-> out_src0 == 9'd256);
    assert_forced_is_zero_src1_R10: assert property (@(posedge clk) disable iff (rst)
        out_forced[1] |-> out_src1 == 9'd256);
    assert_forced_is_zero_src2_R10: assert property (@(posedge clk) disable iff (rst)
        out_forced[2] |-> out_src2 == 9'd256);
    assert_forced_is_zero_dst_R10: assert property (@(posedge clk) disable iff (rst)
        out_forced[3] |-> out_dst == 9'd256);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_forced));

endmodule

bind vreg_reloc_unit vri_checker u_vri_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_src0   (out_src0),
    .out_src1   (out_src1),
    .out_src2   (out_src2),
    .out_dst    (out_dst),
    .out_forced (out_forced),
    .idx_en     (idx_en),
    .idx_mask   (idx_mask)
);

// File: tb/test_vreg_reloc_unit.sv
`timescale 1ns/1ps
module test_vreg_reloc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic [8:0]  vreg_count;
    logic        in_valid;
    logic [8:0]  in_src0, in_src1, in_src2, in_dst;
    logic        out_valid;
    logic [8:0]  out_src0, out_src1, out_src2, out_dst;
    logic [3:0]  out_forced;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit      m_en;
    int      m_idx;
    bit [3:0] m_mask;
    bit      e_valid;
    int      e_spec [4];
    bit [3:0] e_forced;

    always #4 clk = ~clk;

    vreg_reloc_unit i_vreg_reloc_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vreg_count(vreg_count), .in_valid(in_valid),
        .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
        .out_valid(out_valid), .out_src0(out_src0), .out_src1(out_src1),
        .out_src2(out_src2), .out_dst(out_dst), .out_forced(out_forced)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural expectation for one operand lane
    task automatic model_op(int k, int spec, int count);
        int n;
        if (!(m_en && m_mask[k])) begin
            e_spec[k] = spec; e_forced[k] = 1'b0;
        end else if (spec < 256) begin
            e_spec[k] = 256; e_forced[k] = 1'b1;
        end else begin
            n = (spec - 256) + m_idx;
            if (n >= count) begin
                e_spec[k] = 256; e_forced[k] = 1'b1;
            end else begin
                e_spec[k] = 256 + n; e_forced[k] = 1'b0;
            end
        end
    endtask

    // one clock: drive at negedge, compare at the next negedge
    task automatic step(string req, bit we, bit sel, int wdata, bit v,
                        int s0, int s1, int s2, int d, int count);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wdata; in_valid = v;
        in_src0 = 9'(s0); in_src1 = 9'(s1); in_src2 = 9'(s2); in_dst = 9'(d);
        vreg_count = 9'(count);
        e_valid = v;
        if (v) begin
            model_op(0, s0, count); model_op(1, s1, count);
            model_op(2, s2, count); model_op(3, d, count);
        end
        @(negedge clk);
        if (we) begin
            if (!sel) m_en = wdata[27];
            else begin m_idx = wdata & 32'hff; m_mask = 4'(wdata >> 12); end
        end
        chk({req, " valid"}, out_valid, e_valid);
        chk({req, " src0"}, out_src0, e_spec[0]);
        chk({req, " src1"}, out_src1, e_spec[1]);
        chk({req, " src2"}, out_src2, e_spec[2]);
        chk({req, " dst"},  out_dst,  e_spec[3]);
        chk({req, " R10 forced"}, out_forced, e_forced);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; vreg_count = 9'd256;
        in_valid = 0; in_src0 = 0; in_src1 = 0; in_src2 = 0; in_dst = 0;
        m_en = 0; m_idx = 0; m_mask = 0; e_forced = 0;
        for (int k = 0; k < 4; k++) e_spec[k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 valid", out_valid, 0);
        chk("R1 src0", out_src0, 0);
        chk("R1 forced", out_forced, 0);
        rst = 1'b0;
        // R1: indexing starts disabled
        step("R1", 0, 0, 0, 1, 300, 10, 511, 260, 256);
        // R3: mask and index set but enable clear
        step("R3 cfg", 1, 1, 32'h0000_F005, 0, 0, 0, 0, 0, 256);
        step("R3", 0, 0, 0, 1, 300, 5, 400, 256, 16);
        // R9: enable write in same cycle as instruction: old value seen
        step("R9 same", 1, 0, 32'h0800_0000, 1, 300, 5, 400, 256, 16);
        // R4: relocation now active, idx 5, count 16
        step("R4", 0, 0, 0, 1, 256, 258, 261, 266, 16);
        // R6 boundary: 10+5=15 kept, 11+5=16 forced; R8 scalar forced
        step("R6 R8", 0, 0, 0, 1, 266, 267, 12, 300, 16);
        // R2: idle cycle holds outputs
        step("R2 idle", 0, 0, 0, 0, 1, 2, 3, 4, 16);
        step("R2 idle2", 0, 0, 0, 0, 9, 9, 9, 9, 16);
        // R5: one mask bit at a time
        for (int b = 0; b < 4; b++) begin
            step("R5 cfg", 1, 1, (1 << (12 + b)) | 3, 0, 0, 0, 0, 0, 64);
            step("R5", 0, 0, 0, 1, 260, 261, 262, 263, 64);
        end
        // R7: wrap past 255 with all registers allocated
        step("R7 cfg", 1, 1, 32'h0000_F064, 0, 0, 0, 0, 0, 256);
        step("R7", 0, 0, 0, 1, 256 + 200, 256 + 155, 256 + 156, 256 + 100, 256);
        step("R7 max", 0, 0, 0, 1, 256 + 255, 256 + 0, 256 + 154, 256 + 1, 256);
        // R9: index write in same cycle as instruction uses old index 100
        step("R9 idx", 1, 1, 32'h0000_F001, 1, 256 + 10, 256 + 20, 0, 256 + 30, 256);
        step("R9 new", 0, 0, 0, 1, 256 + 10, 256 + 20, 0, 256 + 30, 256);
        // R6: count 1 leaves only register 0 with index 0
        step("R6 cfg", 1, 1, 32'h0000_F000, 0, 0, 0, 0, 0, 1);
        step("R6 one", 0, 0, 0, 1, 256, 257, 100, 511, 1);
        // R3: disable again
        step("R3 off", 1, 0, 0, 1, 256, 257, 100, 511, 1);
        step("R3 pass", 0, 0, 0, 1, 256, 257, 100, 511, 1);
        // R1: reset mid-run clears registers
        rst = 1'b1;
        @(negedge clk);
        chk("R1 rst valid", out_valid, 0);
        chk("R1 rst dst", out_dst, 0);
        rst = 1'b0;
        m_en = 0; m_idx = 0; m_mask = 0;
        step("R1 after", 0, 0, 0, 1, 300, 3, 256, 511, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule